// File: doc/BRIEF.md
# Serial-ATA Host Controller Register File

This block is the software-visible register space of a multi-port serial-ATA host controller. A processor reaches it through a simple 32-bit read/write request bus. It holds a small set of controller-wide registers and one window of registers per port. Each register applies its own write rule: plain store, masked store, write-1-to-clear, write-1-to-set, or read-only.

The link, frame and DMA machinery is not part of this block. That machinery reports into the registers through single-cycle pulse inputs for each port:
- an interrupt-event vector,
- an error-event vector,
- a slot-completion vector.

The block merges every port's enabled pending interrupts into a per-port summary register, and from that drives one level-sensitive interrupt line.

A request is accepted in the cycle in which `req_valid` is high; there is no back-pressure. A read returns its data one cycle later, qualified by `rsp_valid`. A write takes effect at the clock edge that accepts it.

Top module: `sata_hba_regs`

## Requirements
- R1: Only the low 12 address bits are decoded. Controller registers sit below 0x100: capabilities 0x00, control 0x04, interrupt summary 0x08, ports-present 0x0C, version 0x10. Port p occupies 0x100+p*0x80, with these offsets: interrupt status 0x10, interrupt enable 0x14, command 0x18, link status 0x28, link control 0x2C, link error 0x30, queued-active 0x34, issue 0x38. Any other offset, and any address above the last port, reads 0. Read data appears one cycle after the request, with `rsp_valid` high.
- R2: A write whose address has bit 1 or bit 0 set changes no register.
- R3: The capabilities register reads as follows: bits 4:0 hold ports-1, bits 12:8 hold slots-1, bits 23:20 hold 1 and bit 30 is set. Ports-present reads (1<<ports)-1, and version reads the VERSION parameter. Writes to these three registers have no effect.
- R4: Port interrupt status bits are set by `evt_irq` pulses and cleared by writing 1. An event that arrives in the same cycle as a clear wins.
- R5: A write to port interrupt enable stores the data ANDed with 0xFDC000FF.
- R6: In the port command register, bit 15 follows bit 0 of the written value and bit 14 follows bit 4. Written values for bits 15 and 14 are ignored. The command register resets to 0x6.
- R7: Link error bits are set by `evt_err` and cleared by writing 1. The queued-active and issue registers are write-1-to-set, limited to the low NUM_SLOTS bits. A `slot_done` pulse clears the matching bits in both registers.
- R8: A write to link control whose old bits 3:0 equal 1 and whose new bits 3:0 equal 0 resets the port. The reset clears interrupt status, interrupt enable, link status, link error and queued-active. Link control takes the written value. Command and issue keep their values.
- R9: Bit p of the interrupt summary is set in every cycle in which port p has a status bit that is also enabled. The summary is write-1-to-clear, but a still-pending port sets its bit again.
- R10: `irq` is high exactly when the interrupt summary is nonzero and control bit 1 is set.
- R11: A control write with bit 0 set resets the controller. It clears control and the interrupt summary and applies the R8 port reset to every port. A control write with bit 0 clear stores bit 1 and sets bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| evt_irq | input | NUM_PORTS*32 | Interrupt-status set pulses, 32 bits per port |
| evt_err | input | NUM_PORTS*32 | Link-error set pulses, 32 bits per port |
| slot_done | input | NUM_PORTS*NUM_SLOTS | Slot completion pulses per port |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with three ports and eight slots. Three ports is not a power of two, so an address just past the last port window must read zero instead of aliasing onto a port. Eight slots makes the truncation of the issue and queued-active writes visible. Every port is swept through its masked, set and clear registers. The link-control reset, the controller reset and the rule that set wins over clear in the summary are each driven with their boundary values.

// File: rtl/sata_hba_pkg.sv
package sata_hba_pkg;
  localparam logic [12:0] GLOB_SPAN = 13'h100;
  localparam logic [12:0] PORT_SPAN = 13'h080;

  localparam logic [7:0] G_CAP  = 8'h00;
  localparam logic [7:0] G_CTL  = 8'h04;
  localparam logic [7:0] G_SUM  = 8'h08;
  localparam logic [7:0] G_PRES = 8'h0C;
  localparam logic [7:0] G_VER  = 8'h10;

  localparam logic [6:0] P_STAT = 7'h10;
  localparam logic [6:0] P_ENA  = 7'h14;
  localparam logic [6:0] P_CMD  = 7'h18;
  localparam logic [6:0] P_LSTS = 7'h28;
  localparam logic [6:0] P_LCTL = 7'h2C;
  localparam logic [6:0] P_LERR = 7'h30;
  localparam logic [6:0] P_QACT = 7'h34;
  localparam logic [6:0] P_ISS  = 7'h38;

  localparam logic [31:0] ENA_KEEP  = 32'hFDC0_00FF;
  localparam logic [31:0] CMD_INIT  = 32'h0000_0006;
  localparam int CMD_START = 0;
  localparam int CMD_RXEN  = 4;
  localparam int CMD_RXRUN = 14;
  localparam int CMD_RUN   = 15;

  localparam int CTL_RST = 0;
  localparam int CTL_IEN = 1;

  function automatic logic [31:0] cap_word(input int ports, input int slots);
    logic [31:0] w;
    w = '0;
    w[4:0]   = 5'(ports - 1);
    w[12:8]  = 5'(slots - 1);
    w[23:20] = 4'd1;
    w[30]    = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/sata_reg_decode.sv
module sata_reg_decode
  import sata_hba_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [11:0]          req_addr,
  output logic                 glob_hit,
  output logic [NUM_PORTS-1:0] port_hit,
  output logic                 wr_ok,
  output logic                 rd_ok
);
  localparam logic [12:0] WIN_END = 13'(256 + NUM_PORTS * 128);

  logic [12:0] a13;
  logic [12:0] rel;
  logic        in_win;

  always_comb begin
    a13    = {1'b0, req_addr};
    rel    = a13 - GLOB_SPAN;
    in_win = (a13 >= GLOB_SPAN) && (a13 < WIN_END);
    glob_hit = (a13 < GLOB_SPAN);
    wr_ok  = req_valid && req_write && (req_addr[1:0] == 2'b00);
    rd_ok  = req_valid && !req_write;
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_hit
    assign port_hit[i] = in_win && (rel[11:7] == 5'(i));
  end
endmodule

// File: rtl/sata_port_regs.sv
module sata_port_regs
  import sata_hba_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hba_rst,
  input  logic                 wr_en,
  input  logic [6:0]           off,
  input  logic [31:0]          wdata,
  input  logic [31:0]          evt_irq,
  input  logic [31:0]          evt_err,
  input  logic [NUM_SLOTS-1:0] slot_done,
  output logic [31:0]          rdata,
  output logic                 pend
);
  logic [31:0] stat_q, ena_q, cmd_q, lsts_q, lctl_q, lerr_q;
  logic [NUM_SLOTS-1:0] qact_q, iss_q;

  logic wr_stat, wr_ena, wr_cmd, wr_lsts, wr_lctl, wr_lerr, wr_qact, wr_iss;
  logic det_fall, prst;
  logic [31:0] cmd_new;

  always_comb begin
    wr_stat = wr_en && (off == P_STAT);
    wr_ena  = wr_en && (off == P_ENA);
    wr_cmd  = wr_en && (off == P_CMD);
    wr_lsts = wr_en && (off == P_LSTS);
    wr_lctl = wr_en && (off == P_LCTL);
    wr_lerr = wr_en && (off == P_LERR);
    wr_qact = wr_en && (off == P_QACT);
    wr_iss  = wr_en && (off == P_ISS);
    det_fall = wr_lctl && (lctl_q[3:0] == 4'd1) && (wdata[3:0] == 4'd0);
    prst     = hba_rst || det_fall;
    cmd_new  = wdata;
    cmd_new[CMD_RUN]   = wdata[CMD_START];
    cmd_new[CMD_RXRUN] = wdata[CMD_RXEN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ena_q  <= '0;
      cmd_q  <= CMD_INIT;
      lsts_q <= '0;
      lctl_q <= '0;
      lerr_q <= '0;
      qact_q <= '0;
      iss_q  <= '0;
    end else begin
      if (prst) stat_q <= evt_irq;
      else      stat_q <= (stat_q & ~(wr_stat ? wdata : 32'h0)) | evt_irq;

      if (prst)        ena_q <= '0;
      else if (wr_ena) ena_q <= wdata & ENA_KEEP;

      if (wr_cmd) cmd_q <= cmd_new;

      if (prst)         lsts_q <= '0;
      else if (wr_lsts) lsts_q <= wdata;

      if (wr_lctl)      lctl_q <= wdata;
      else if (hba_rst) lctl_q <= '0;

      if (prst) lerr_q <= evt_err;
      else      lerr_q <= (lerr_q & ~(wr_lerr ? wdata : 32'h0)) | evt_err;

      if (prst) qact_q <= '0;
      else      qact_q <= (qact_q | (wr_qact ? wdata[NUM_SLOTS-1:0] : '0)) & ~slot_done;

      iss_q <= (iss_q | (wr_iss ? wdata[NUM_SLOTS-1:0] : '0)) & ~slot_done;
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      P_STAT: rdata = stat_q;
      P_ENA:  rdata = ena_q;
      P_CMD:  rdata = cmd_q;
      P_LSTS: rdata = lsts_q;
      P_LCTL: rdata = lctl_q;
      P_LERR: rdata = lerr_q;
      P_QACT: rdata[NUM_SLOTS-1:0] = qact_q;
      P_ISS:  rdata[NUM_SLOTS-1:0] = iss_q;
      default: rdata = '0;
    endcase
    pend = |(stat_q & ena_q);
  end

  // R4
  stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !prst) |=> ((stat_q & $past(wdata) & ~$past(evt_irq)) == 32'h0));

  // R5
  ena_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q & ~ENA_KEEP) == 32'h0);

  // R6
  cmd_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[CMD_RUN] == cmd_q[CMD_START]) && (cmd_q[CMD_RXRUN] == cmd_q[CMD_RXEN]));

  // R7
  qact_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_qact && !prst && (slot_done == '0)) |=>
      ((qact_q & $past(wdata[NUM_SLOTS-1:0])) == $past(wdata[NUM_SLOTS-1:0])));

  // R8
  det_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_fall |=> (ena_q == 32'h0) && (qact_q == '0) && (lsts_q == 32'h0));
endmodule

// File: rtl/sata_glob_regs.sv
module sata_glob_regs
  import sata_hba_pkg::*;
#(
  parameter int          NUM_PORTS = 4,
  parameter int          NUM_SLOTS = 32,
  parameter logic [31:0] VERSION   = 32'h0001_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           off,
  input  logic [31:0]          wdata,
  input  logic [NUM_PORTS-1:0] pend,
  output logic [31:0]          rdata,
  output logic                 hba_rst,
  output logic                 irq
);
  localparam logic [31:0] CAP_VAL  = cap_word(NUM_PORTS, NUM_SLOTS);
  localparam logic [31:0] PRES_VAL = 32'((64'd1 << NUM_PORTS) - 64'd1);

  logic                 ien_q, aen_q;
  logic [NUM_PORTS-1:0] sum_q;
  logic                 wr_ctl, wr_sum;

  always_comb begin
    wr_ctl  = wr_en && (off == G_CTL);
    wr_sum  = wr_en && (off == G_SUM);
    hba_rst = wr_ctl && wdata[CTL_RST];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      aen_q <= 1'b0;
      sum_q <= '0;
    end else if (hba_rst) begin
      ien_q <= 1'b0;
      aen_q <= 1'b0;
      sum_q <= '0;
    end else begin
      if (wr_ctl) begin
        ien_q <= wdata[CTL_IEN];
        aen_q <= 1'b1;
      end
      sum_q <= (sum_q & ~(wr_sum ? wdata[NUM_PORTS-1:0] : '0)) | pend;
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      G_CAP:  rdata = CAP_VAL;
      G_CTL:  begin rdata[31] = aen_q; rdata[CTL_IEN] = ien_q; end
      G_SUM:  rdata[NUM_PORTS-1:0] = sum_q;
      G_PRES: rdata = PRES_VAL;
      G_VER:  rdata = VERSION;
      default: rdata = '0;
    endcase
    irq = (|sum_q) && ien_q;
  end

  // R9
  pend_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pend) && !hba_rst) |=> ((sum_q & $past(pend)) == $past(pend)));

  // R11
  hba_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hba_rst |=> (sum_q == '0) && !ien_q && !aen_q);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q) |-> !irq);
endmodule

// File: rtl/sata_hba_regs.sv
module sata_hba_regs
  import sata_hba_pkg::*;
#(
  parameter int          NUM_PORTS = 4,
  parameter int          NUM_SLOTS = 32,
  parameter logic [31:0] VERSION   = 32'h0001_0000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [11:0]                    req_addr,
  input  logic [31:0]                    req_wdata,
  output logic                           rsp_valid,
  output logic [31:0]                    rsp_rdata,
  input  logic [NUM_PORTS*32-1:0]        evt_irq,
  input  logic [NUM_PORTS*32-1:0]        evt_err,
  input  logic [NUM_PORTS*NUM_SLOTS-1:0] slot_done,
  output logic                           irq
);
  logic                 glob_hit, wr_ok, rd_ok, hba_rst;
  logic [NUM_PORTS-1:0] port_hit, pend;
  logic [31:0]          glob_rdata;
  logic [31:0]          port_rdata [NUM_PORTS];
  logic [31:0]          rd_mux;

  sata_reg_decode #(.NUM_PORTS(NUM_PORTS)) dec_i (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .glob_hit(glob_hit), .port_hit(port_hit), .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  sata_glob_regs #(.NUM_PORTS(NUM_PORTS), .NUM_SLOTS(NUM_SLOTS), .VERSION(VERSION)) glob_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok && glob_hit), .off(req_addr[7:0]),
    .wdata(req_wdata), .pend(pend), .rdata(glob_rdata), .hba_rst(hba_rst), .irq(irq)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sata_port_regs #(.NUM_SLOTS(NUM_SLOTS)) port_i (
      .clk(clk), .rst_n(rst_n), .hba_rst(hba_rst),
      .wr_en(wr_ok && port_hit[p]), .off(req_addr[6:0]), .wdata(req_wdata),
      .evt_irq(evt_irq[p*32 +: 32]), .evt_err(evt_err[p*32 +: 32]),
      .slot_done(slot_done[p*NUM_SLOTS +: NUM_SLOTS]),
      .rdata(port_rdata[p]), .pend(pend[p])
    );
  end

  always_comb begin
    rd_mux = glob_hit ? glob_rdata : 32'h0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_hit[p]) rd_mux = port_rdata[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_ok;
      rsp_rdata <= rd_ok ? rd_mux : 32'h0;
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R1
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R2
  misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (req_addr[1:0] != 2'b00)) |=> !$past(hba_rst));
endmodule

// File: tb/sata_hba_regs_tb_top.sv
module sata_hba_regs_tb_top;
  localparam int NP = 3;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP*32-1:0] evt_irq = '0, evt_err = '0;
  logic [NP*NS-1:0] slot_done = '0;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sata_hba_regs #(.NUM_PORTS(NP), .NUM_SLOTS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .evt_irq(evt_irq), .evt_err(evt_err),
    .slot_done(slot_done), .irq(irq)
  );

  function automatic logic [11:0] pa(input int p, input logic [6:0] off);
    return 12'(256 + p * 128) + 12'(off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_irq(input int p, input logic [31:0] v);
    @(negedge clk); evt_irq[p*32 +: 32] = v;
    @(negedge clk); evt_irq = '0;
  endtask

  task automatic pulse_err(input int p, input logic [31:0] v);
    @(negedge clk); evt_err[p*32 +: 32] = v;
    @(negedge clk); evt_err = '0;
  endtask

  task automatic pulse_done(input int p, input logic [NS-1:0] v);
    @(negedge clk); slot_done[p*NS +: NS] = v;
    @(negedge clk); slot_done = '0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] cap_exp;
    cap_exp = 32'(NP - 1) | (32'(NS - 1) << 8) | (32'd1 << 20) | (32'd1 << 30);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rchk("R11 ctl reset", 12'h004, 32'h0);
    rchk("R9 sum reset", 12'h008, 32'h0);
    for (int p = 0; p < NP; p++) begin
      rchk("R6 cmd reset", pa(p, 7'h18), 32'h6);
      rchk("R4 stat reset", pa(p, 7'h10), 32'h0);
    end

    // R3 constant registers, read-only
    rchk("R3 cap", 12'h000, cap_exp);
    rchk("R3 present", 12'h00C, 32'h7);
    rchk("R3 version", 12'h010, 32'h0001_0000);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h00C, 32'h0);
    wr(12'h010, 32'h0);
    rchk("R3 cap ro", 12'h000, cap_exp);
    rchk("R3 present ro", 12'h00C, 32'h7);
    rchk("R3 version ro", 12'h010, 32'h0001_0000);

    // R1 decode
    rchk("R1 undefined global", 12'h0FC, 32'h0);
    rchk("R1 beyond last port", pa(NP, 7'h14), 32'h0);
    rchk("R1 undefined port offset", pa(0, 7'h04), 32'h0);

    // R5 and R2 sweep over ports
    for (int p = 0; p < NP; p++) begin
      wr(pa(p, 7'h14), 32'hFFFF_FFFF);
      rchk("R5 enable mask", pa(p, 7'h14), 32'hFDC0_00FF);
      wr(pa(p, 7'h14), 32'h0000_0001 << p);
      wr(pa(p, 7'h16), 32'h0);
      wr(pa(p, 7'h15), 32'h0);
      rchk("R2 misaligned dropped", pa(p, 7'h14), 32'h0000_0001 << p);
      wr(pa(p, 7'h14), 32'h0);
    end

    // R4 status set/clear sweep
    for (int p = 0; p < NP; p++) begin
      logic [31:0] pat;
      pat = (32'h1 << (p * 5 + 3)) | 32'hA000_0000;
      pulse_irq(p, pat);
      rchk("R4 status set", pa(p, 7'h10), pat);
      wr(pa(p, 7'h10), 32'h8000_0000);
      rchk("R4 status partial clear", pa(p, 7'h10), pat & 32'h7FFF_FFFF);
      wr(pa(p, 7'h10), 32'hFFFF_FFFF);
      rchk("R4 status all clear", pa(p, 7'h10), 32'h0);
    end

    // R9 / R10 summary and interrupt line
    wr(pa(1, 7'h14), 32'h1);
    pulse_irq(1, 32'h1);
    rchk("R9 summary set", 12'h008, 32'h2);
    chk("R10 irq gated off", {31'b0, irq}, 32'h0);
    wr(12'h004, 32'h2);
    rchk("R11 ctl store", 12'h004, 32'h8000_0002);
    chk("R10 irq high", {31'b0, irq}, 32'h1);
    wr(12'h008, 32'h2);
    rchk("R9 pending resets summary", 12'h008, 32'h2);
    wr(pa(1, 7'h10), 32'h1);
    wr(12'h008, 32'h2);
    rchk("R9 summary cleared", 12'h008, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    wr(pa(1, 7'h14), 32'h0);

    // R6 command mirrors
    wr(pa(0, 7'h18), 32'h11);
    rchk("R6 both running", pa(0, 7'h18), 32'hC011);
    wr(pa(0, 7'h18), 32'hC000);
    rchk("R6 running ignored", pa(0, 7'h18), 32'h0);
    wr(pa(0, 7'h18), 32'h10);
    rchk("R6 rx running only", pa(0, 7'h18), 32'h4010);

    // R7 queued-active, issue, link error
    wr(pa(1, 7'h34), 32'h3);
    wr(pa(1, 7'h34), 32'h104);
    rchk("R7 qact set", pa(1, 7'h34), 32'h7);
    pulse_done(1, 8'h02);
    rchk("R7 qact done", pa(1, 7'h34), 32'h5);
    wr(pa(1, 7'h38), 32'hFFF0);
    rchk("R7 issue set", pa(1, 7'h38), 32'hF0);
    pulse_done(1, 8'h10);
    rchk("R7 issue done", pa(1, 7'h38), 32'hE0);
    pulse_err(1, 32'hF0);
    wr(pa(1, 7'h30), 32'h30);
    rchk("R7 lerr w1c", pa(1, 7'h30), 32'hC0);

    // R8 link-control falling detect
    wr(pa(2, 7'h2C), 32'h1);
    wr(pa(2, 7'h14), 32'hFF);
    pulse_irq(2, 32'h3);
    wr(pa(2, 7'h34), 32'h1);
    pulse_err(2, 32'h1);
    wr(pa(2, 7'h28), 32'h123);
    wr(pa(2, 7'h38), 32'h8);
    wr(pa(2, 7'h2C), 32'h300);
    rchk("R8 lctl written", pa(2, 7'h2C), 32'h300);
    rchk("R8 ena cleared", pa(2, 7'h14), 32'h0);
    rchk("R8 stat cleared", pa(2, 7'h10), 32'h0);
    rchk("R8 qact cleared", pa(2, 7'h34), 32'h0);
    rchk("R8 lerr cleared", pa(2, 7'h30), 32'h0);
    rchk("R8 lsts cleared", pa(2, 7'h28), 32'h0);
    rchk("R8 issue kept", pa(2, 7'h38), 32'h8);
    wr(12'h008, 32'h7);
    wr(pa(0, 7'h2C), 32'h2);
    wr(pa(0, 7'h14), 32'h1);
    wr(pa(0, 7'h2C), 32'h0);
    rchk("R8 no reset from 2", pa(0, 7'h14), 32'h1);

    // R11 controller reset
    pulse_irq(0, 32'h1);
    wr(12'h004, 32'h2);
    chk("R10 irq before reset", {31'b0, irq}, 32'h1);
    wr(12'h004, 32'h3);
    rchk("R11 ctl cleared", 12'h004, 32'h0);
    rchk("R11 sum cleared", 12'h008, 32'h0);
    rchk("R11 port ena cleared", pa(0, 7'h14), 32'h0);
    rchk("R11 cmd kept", pa(0, 7'h18), 32'h4010);
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule